// File: doc/BRIEF.md
# Data Tenure Sequencer for a Split-Phase Bus Master

This block runs the data phase of one transfer on a bus whose address and data phases are separate. A requester presents a transfer (direction, single or four-beat burst, and the write data for every beat) and holds it there. Once the address phase has been acknowledged, the sequencer claims the data bus with a busy signal. It then steps through the beats. Each beat ends only when the target returns a transfer acknowledge, and any cycle without one is a wait state.

On writes the sequencer enables the data drivers and presents the current beat's word unchanged until that beat is acknowledged. On reads it captures the bus into a per-beat register at each acknowledge. An error acknowledge ends the tenure at once: busy drops the next cycle and an error flag is set. Data already captured is kept. A one-cycle completion pulse marks the end of every tenure, whether it ended normally or on an error.

Top module: `data_tenure_seq`

## Requirements
- R1: After reset, `dbb`, `data_oe`, `done` and `error` are low and `rd_data` is all zeros.
- R2: `dbb` rises in the cycle after a clock edge that samples `aack` high together with `req_valid` while the block is idle. An `aack` without `req_valid` starts nothing, and `ta`/`tea` while idle have no effect.
- R3: A beat advances only on a clock edge that samples `ta` high. While `dbb` is high and `ta` is low, `dbb` stays high, `data_out` keeps the current beat's word, and `rd_data` does not change.
- R4: A burst (`req_burst`=1) has 4 beats and a single transfer has 1. Each sampled `ta` advances exactly one beat, even when `ta` pulses between wait states. `dbb` falls in the cycle after the last beat's `ta`.
- R5: On writes, `data_oe` is high exactly while `dbb` is high, and during beat k `data_out` equals `req_wdata[k*DATA_W +: DATA_W]` (beat 0 in the low bits). On reads, `data_oe` stays low.
- R6: On reads, the `data_in` value sampled with the `ta` of beat k is stored in `rd_data[k*DATA_W +: DATA_W]`.
- R7: A `tea` sampled while `dbb` is high makes `dbb` low the next cycle, raises `error` and pulses `done` in that cycle, and leaves the `rd_data` slices of beats already captured unchanged.
- R8: If `ta` and `tea` are sampled in the same cycle, the error wins: the tenure ends with `error` set and no data is captured for that beat.
- R9: On reads, `tea` is also honoured in the one cycle after the final `ta`. `done` for a read therefore comes two cycles after the final `ta`, and a `tea` in that cycle sets `error`.
- R10: `done` is high for exactly one cycle per tenure. For writes it comes in the cycle after the final `ta`. `error` holds its value until the next tenure starts, and the start clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A transfer is pending |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | 1 = four-beat burst, 0 = single beat |
| req_wdata | input | NBEATS*DATA_W | Write words, beat 0 in the low bits; held until done |
| aack | input | 1 | Address phase acknowledge strobe |
| ta | input | 1 | Transfer acknowledge, one per beat |
| tea | input | 1 | Error acknowledge |
| data_in | input | DATA_W | Data bus, read direction |
| dbb | output | 1 | Data bus busy |
| data_oe | output | 1 | Data bus drive enable |
| data_out | output | DATA_W | Data bus, write direction |
| rd_data | output | NBEATS*DATA_W | Captured read words, beat k at slice k |
| done | output | 1 | One-cycle end-of-tenure pulse |
| error | output | 1 | Tenure ended on an error acknowledge |

## Verification
The hardest case to reach from the ports is the read-only window just after the final acknowledge. In that cycle busy is already low, but an error acknowledge must still count. The stimulus reaches it by holding a single read in wait states, acknowledging it, and then raising the error strobe exactly one cycle later. It then checks that the captured word survives and that the completion pulse carries the error. A second hard case is an abort in the middle of a burst. A completed burst read first fills every slice with known values. Two beats of a second burst then overwrite the low slices before the error arrives, so the bench can see both the retained new data and the untouched old slices.

// File: rtl/dts_pkg.sv
package dts_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_TAIL = 2'd2
  } tenure_st_e;
endpackage

// File: rtl/dts_beat_ctr.sv
module dts_beat_ctr #(
  parameter int NBEATS = 4,
  localparam int BW = $clog2(NBEATS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  input  logic          burst,
  output logic [BW-1:0] cnt,
  output logic          last
);
  logic [BW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (clr)      cnt_d = '0;
    else if (adv) cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  assign last = burst ? (cnt == BW'(NBEATS - 1)) : (cnt == '0);
endmodule

// File: rtl/dts_rd_capture.sv
module dts_rd_capture #(
  parameter int DATA_W = 32,
  parameter int NBEATS = 4,
  localparam int BW = $clog2(NBEATS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wen,
  input  logic [BW-1:0]            idx,
  input  logic [DATA_W-1:0]        din,
  output logic [NBEATS*DATA_W-1:0] dout
);
  for (genvar g = 0; g < NBEATS; g++) begin : g_slot
    logic en;
    assign en = wen && (idx == BW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  dout[g*DATA_W +: DATA_W] <= '0;
      else if (en) dout[g*DATA_W +: DATA_W] <= din;
    end
  end
endmodule

// File: rtl/data_tenure_seq.sv
module data_tenure_seq
  import dts_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NBEATS = 4,
  localparam int BW = $clog2(NBEATS),
  localparam int VW = NBEATS * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_burst,
  input  logic [VW-1:0]     req_wdata,
  input  logic              aack,
  input  logic              ta,
  input  logic              tea,
  input  logic [DATA_W-1:0] data_in,
  output logic              dbb,
  output logic              data_oe,
  output logic [DATA_W-1:0] data_out,
  output logic [VW-1:0]     rd_data,
  output logic              done,
  output logic              error
);
  tenure_st_e    st_q, st_d;
  logic          wr_q, wr_d, burst_q, burst_d;
  logic          done_d, err_d;
  logic          start, adv, last, cap_en;
  logic [BW-1:0] beat;

  always_comb begin
    st_d    = st_q;
    wr_d    = wr_q;
    burst_d = burst_q;
    done_d  = 1'b0;
    err_d   = error;
    start   = 1'b0;
    adv     = 1'b0;
    cap_en  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid && aack) begin
          start   = 1'b1;
          st_d    = ST_DATA;
          wr_d    = req_write;
          burst_d = req_burst;
          err_d   = 1'b0;
        end
      end
      ST_DATA: begin
        if (tea) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
          err_d  = 1'b1;
        end else if (ta) begin
          adv    = !last;
          cap_en = !wr_q;
          if (last) begin
            if (wr_q) begin
              st_d   = ST_IDLE;
              done_d = 1'b1;
            end else begin
              st_d = ST_TAIL;
            end
          end
        end
      end
      ST_TAIL: begin
        st_d   = ST_IDLE;
        done_d = 1'b1;
        if (tea) err_d = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      wr_q    <= 1'b0;
      burst_q <= 1'b0;
      done    <= 1'b0;
      error   <= 1'b0;
    end else begin
      st_q    <= st_d;
      wr_q    <= wr_d;
      burst_q <= burst_d;
      done    <= done_d;
      error   <= err_d;
    end
  end

  dts_beat_ctr #(.NBEATS(NBEATS)) u_ctr (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (start),
    .adv  (adv),
    .burst(burst_q),
    .cnt  (beat),
    .last (last)
  );

  dts_rd_capture #(.DATA_W(DATA_W), .NBEATS(NBEATS)) u_cap (
    .clk  (clk),
    .rst_n(rst_n),
    .wen  (cap_en),
    .idx  (beat),
    .din  (data_in),
    .dout (rd_data)
  );

  assign dbb      = (st_q == ST_DATA);
  assign data_oe  = dbb && wr_q;
  assign data_out = req_wdata[beat*DATA_W +: DATA_W];
endmodule

// File: rtl/dts_checker.sv
module dts_checker #(
  parameter int DATA_W = 32,
  parameter int NBEATS = 4,
  localparam int VW = NBEATS * DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              aack,
  input logic              ta,
  input logic              tea,
  input logic              dbb,
  input logic              data_oe,
  input logic [DATA_W-1:0] data_out,
  input logic [VW-1:0]     rd_data,
  input logic              done,
  input logic              error
);
  a_r2_start_after_aack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dbb) |-> $past(aack && req_valid));

  a_r3_wait_holds_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (dbb && !ta && !tea) |=> dbb);

  a_r3_wait_holds_wdata: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe && !ta && !tea) |=> $stable(data_out));

  a_r3_wait_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (dbb && !ta) |=> $stable(rd_data));

  a_r5_oe_within_busy: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> dbb);

  a_r7_error_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (dbb && tea) |=> (!dbb && error && done));

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind data_tenure_seq dts_checker #(.DATA_W(DATA_W), .NBEATS(NBEATS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .aack     (aack),
  .ta       (ta),
  .tea      (tea),
  .dbb      (dbb),
  .data_oe  (data_oe),
  .data_out (data_out),
  .rd_data  (rd_data),
  .done     (done),
  .error    (error)
);

// File: tb/data_tenure_seq_bench.sv
module data_tenure_seq_bench;
  localparam int W  = 32;
  localparam int NB = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_write, req_burst, aack, ta, tea;
  logic [NB*W-1:0] req_wdata;
  logic [W-1:0]  data_in;
  logic          dbb, data_oe, done, error;
  logic [W-1:0]  data_out;
  logic [NB*W-1:0] rd_data;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  data_tenure_seq #(.DATA_W(W), .NBEATS(NB)) u_data_tenure_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_burst(req_burst), .req_wdata(req_wdata), .aack(aack), .ta(ta),
    .tea(tea), .data_in(data_in), .dbb(dbb), .data_oe(data_oe),
    .data_out(data_out), .rd_data(rd_data), .done(done), .error(error)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic t, input logic e);
    ta = t; tea = e;
    @(negedge clk);
    ta = 1'b0; tea = 1'b0;
  endtask

  task automatic begin_tenure(input logic wr, input logic bu);
    req_valid = 1'b1; req_write = wr; req_burst = bu; aack = 1'b1;
    chk(dbb == 1'b0, "R2 busy before aack", dbb, 0);
    step(0, 0);
    aack = 1'b0; req_valid = 1'b0;
    chk(dbb == 1'b1, "R2 busy after aack", dbb, 1);
    chk(error == 1'b0, "R10 error cleared at start", error, 0);
  endtask

  task automatic t_reset();
    chk(dbb == 0 && data_oe == 0, "R1 reset bus", {dbb, data_oe}, 0);
    chk(done == 0 && error == 0, "R1 reset flags", {done, error}, 0);
    chk(rd_data == '0, "R1 reset rd_data", rd_data, 0);
  endtask

  task automatic t_idle_ignore();
    aack = 1'b1; req_valid = 1'b0;
    step(0, 0);
    aack = 1'b0;
    chk(dbb == 0, "R2 aack without request", dbb, 0);
    step(1, 1);
    chk(done == 0 && error == 0 && dbb == 0, "R2 idle ta/tea ignored",
        {dbb, done, error}, 0);
  endtask

  task automatic t_burst_write();
    req_wdata = {32'hD3D3_0003, 32'hD2D2_0002, 32'hD1D1_0001, 32'hD0D0_0000};
    begin_tenure(1, 1);
    for (int k = 0; k < NB; k++) begin
      chk(data_oe == 1, "R5 oe during write", data_oe, 1);
      chk(data_out == req_wdata[k*W +: W], "R5 beat word", data_out, req_wdata[k*W +: W]);
      step(0, 0);
      chk(dbb == 1 && data_out == req_wdata[k*W +: W], "R3 wait holds word",
          data_out, req_wdata[k*W +: W]);
      step(1, 0);
      if (k < NB - 1) chk(dbb == 1, "R4 busy mid burst", dbb, 1);
    end
    chk(dbb == 0 && data_oe == 0, "R4 busy drops after 4th ta", {dbb, data_oe}, 0);
    chk(done == 1 && error == 0, "R10 write done", {done, error}, 2'b10);
    step(0, 0);
    chk(done == 0, "R10 done one cycle", done, 0);
  endtask

  task automatic t_single_read();
    begin_tenure(0, 0);
    chk(data_oe == 0, "R5 no drive on read", data_oe, 0);
    data_in = 32'hAAAA_1111;
    step(0, 0);
    step(0, 0);
    chk(rd_data == '0 && dbb == 1, "R3 wait no capture", rd_data, 0);
    step(1, 0);
    data_in = 32'h0;
    chk(dbb == 0 && done == 0, "R9 tail cycle", {dbb, done}, 0);
    chk(rd_data[W-1:0] == 32'hAAAA_1111, "R6 beat0 captured", rd_data[W-1:0], 32'hAAAA_1111);
    step(0, 0);
    chk(done == 1 && error == 0, "R9 read done late", {done, error}, 2'b10);
  endtask

  task automatic t_burst_read_pulsed();
    logic [NB*W-1:0] exp;
    exp = {32'h4444_0004, 32'h3333_0003, 32'h2222_0002, 32'h1111_0001};
    begin_tenure(0, 1);
    for (int k = 0; k < NB; k++) begin
      data_in = exp[k*W +: W];
      step(1, 0);
      data_in = 32'hDEAD_BEEF;
      if (k < NB - 1) begin
        step(0, 0);
        chk(dbb == 1, "R4 ta pulse advances one beat", dbb, 1);
      end
    end
    chk(dbb == 0, "R4 read burst busy drop", dbb, 0);
    step(0, 0);
    chk(done == 1, "R10 burst read done", done, 1);
    chk(rd_data == exp, "R6 all beats captured", rd_data, exp);
  endtask

  task automatic t_error_mid_burst();
    logic [NB*W-1:0] exp;
    exp = rd_data;
    exp[0 +: W] = 32'hB0B0_0000;
    exp[W +: W] = 32'hB1B1_0001;
    begin_tenure(0, 1);
    data_in = 32'hB0B0_0000; step(1, 0);
    data_in = 32'hB1B1_0001; step(1, 0);
    data_in = 32'hBAD0_BAD0; step(0, 0);
    step(0, 1);
    chk(dbb == 0, "R7 busy released", dbb, 0);
    chk(done == 1 && error == 1, "R7 error done", {done, error}, 2'b11);
    chk(rd_data == exp, "R7 captured data kept", rd_data, exp);
    step(0, 0);
    chk(error == 1 && done == 0, "R10 error held", {done, error}, 2'b01);
  endtask

  task automatic t_ta_tea_same();
    logic [W-1:0] old;
    old = rd_data[W-1:0];
    begin_tenure(0, 0);
    data_in = 32'hCCCC_CCCC;
    step(1, 1);
    chk(dbb == 0 && done == 1 && error == 1, "R8 error wins", {dbb, done, error}, 3'b011);
    chk(rd_data[W-1:0] == old, "R8 no capture", rd_data[W-1:0], old);
    step(0, 0);
  endtask

  task automatic t_tail_error();
    begin_tenure(0, 0);
    data_in = 32'h5555_7777;
    step(0, 0);
    step(1, 0);
    step(0, 1);
    chk(done == 1 && error == 1, "R9 tail tea error", {done, error}, 2'b11);
    chk(rd_data[W-1:0] == 32'h5555_7777, "R9 tail keeps data", rd_data[W-1:0], 32'h5555_7777);
    step(0, 0);
  endtask

  task automatic t_single_write_err_clear();
    req_wdata = {96'h0, 32'h1234_5678};
    begin_tenure(1, 0);
    chk(data_out == 32'h1234_5678, "R5 single word", data_out, 32'h1234_5678);
    step(1, 0);
    chk(done == 1 && error == 0 && dbb == 0, "R10 single write clean done",
        {dbb, done, error}, 3'b010);
    step(0, 0);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 0; req_write = 0; req_burst = 0; aack = 0;
    ta = 0; tea = 0; data_in = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_ignore();
    t_burst_write();
    t_single_read();
    t_burst_read_pulsed();
    t_error_mid_burst();
    t_ta_tea_same();
    t_tail_error();
    t_single_write_err_clear();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule